// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is the host-facing front end of a display controller. A microprocessor reaches the controller's instruction and data registers through it. Two strap inputs pick the transfer shape: serial, 4-bit parallel or 8-bit parallel. A third strap picks the strobe protocol. One protocol has separate active-low write and read strobes. The other uses a direction level and an enable strobe. The same two control pins take the meaning that the protocol strap gives them.

All host pins are asynchronous to the core clock. The block brings them into the clock domain through a synchronizer and finds strobe edges there. It assembles nibbles or serial bits into whole bytes. For each completed byte it presents a single-cycle write pulse to the core, carrying the byte and the register-select bit. On reads it puts the core's register contents onto the data lines behind an output enable. In 4-bit mode it splits the byte into two nibbles. It signals the end of each full byte read to the core.

Top module: `hostbus_port`

## Requirements
- R1: While `rst_n` is low, `wr_valid`, `rd_ack`, `dout_oe` and `dout` are 0. Reset also clears the nibble phase and the serial bit count, so the first transfer after reset is a high nibble or a first serial bit.
- R2: With `sel_6800`=0 and 8-bit parallel mode (`sel_par`=1, `sel_wide`=1), a rising edge on `ctl_wr` while `cs_n` is low produces one `wr_valid` cycle, with `wr_data`=`din` and `wr_rs`=`rs`. A pin change first sampled at clock edge n takes effect on the outputs at edge n+2.
- R3: With `sel_6800`=1, a falling edge on `ctl_en` while `ctl_wr` is low and `cs_n` is low produces one `wr_valid` cycle, with `wr_data`=`din` and `wr_rs`=`rs`.
- R4: Strobe edges and read conditions seen while `cs_n` is high produce no write pulse, no read acknowledge and no bus drive.
- R5: `wr_rs` reproduces `rs` (0 = instruction register, 1 = data register). A read returns `rd_ir_data` when `rs` is 0 and `rd_dr_data` when `rs` is 1.
- R6: In 4-bit mode (`sel_par`=1, `sel_wide`=0) a byte is written as two transfers on `din[7:4]`, high nibble first. `wr_valid` rises only after the second transfer, with `wr_rs` taken from the second transfer.
- R7: In 8-bit mode, `dout_oe` is 1 exactly while `cs_n` is low and the read condition holds. In the 8080-style protocol the read condition is `ctl_en` low. In the 6800-style protocol it is `ctl_wr` high together with `ctl_en` high. `dout` then carries the selected byte. `rd_ack` pulses for one cycle when the read ends, and that end is a rising `ctl_en` in the 8080-style protocol or a falling `ctl_en` with `ctl_wr` high in the 6800-style protocol.
- R8: In 4-bit mode the first read drives the high nibble of the selected byte on `dout[7:4]` and the second read drives the low nibble. `dout[3:0]` stays 0. `rd_ack` pulses only after the second read.
- R9: With `sel_par`=0 the port is serial and `sel_wide` has no effect. Each rising `ctl_wr` edge with `cs_n` low shifts in `din[0]`, MSB first. The eighth bit produces one `wr_valid` cycle with the assembled byte and the current `rs`. `cs_n` high discards a partial byte. `dout_oe` stays 0.
- R10: `dout` is 0 whenever `dout_oe` is 0. A single completed byte never gives `wr_valid` or `rd_ack` for more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_6800 | input | 1 | Protocol strap: 0 = separate strobes, 1 = direction plus enable |
| sel_par | input | 1 | 0 = serial, 1 = parallel |
| sel_wide | input | 1 | Parallel width: 0 = 4-bit, 1 = 8-bit |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 0 instruction, 1 data |
| ctl_wr | input | 1 | Write strobe (active low), direction level, or serial clock |
| ctl_en | input | 1 | Read strobe (active low) or enable |
| din | input | DW | Host data lines in |
| rd_ir_data | input | DW | Instruction-register read value from core |
| rd_dr_data | input | DW | Data-register read value from core |
| wr_valid | output | 1 | One-cycle pulse for a completed byte write |
| wr_data | output | DW | Byte written |
| wr_rs | output | 1 | Register select of the write |
| rd_ack | output | 1 | One-cycle pulse when a full byte read ends |
| dout | output | DW | Host data lines out |
| dout_oe | output | 1 | Output enable for the data lines |

## Verification
A wrong nibble phase or serial bit count is not visible until the next byte finishes. It then shows up as a missing or early `wr_valid`, as swapped nibbles in `wr_data`, or as the wrong half on `dout[7:4]`. That is at most two transfers after the fault. Errors in strobe decoding show within two clock edges of the offending pin edge, as a pulse in the wrong protocol or with chip select high. The reference model therefore compares every output on every cycle. It runs mixed sequences that cross protocols and widths, and it applies reset between the two halves of a byte.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic [1:0] {
    XF_SERIAL = 2'd0,
    XF_NIB4   = 2'd1,
    XF_BYTE8  = 2'd2
  } xfer_mode_e;

  typedef struct packed {
    logic cs_on;
    logic wr;
    logic rd_end;
    logic rd_act;
    logic sclk;
  } bus_evt_t;

  function automatic xfer_mode_e mode_of(input logic par, input logic wide);
    if (!par)     return XF_SERIAL;
    else if (wide) return XF_BYTE8;
    else           return XF_NIB4;
  endfunction

endpackage

// File: rtl/hostbus_rst_sync.sv
module hostbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_i_n = chain_q[STAGES-1];
endmodule

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [W-1:0] stage_d;
      if (gi == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RST_VAL;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hostbus_strobe_decode.sv
module hostbus_strobe_decode
  import hostbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       proto_6800,
  input  xfer_mode_e mode,
  input  logic       cs_n_s,
  input  logic       wr_s,
  input  logic       en_s,
  output bus_evt_t   evt
);
  logic wr_p_q, en_p_q;
  logic wr_p_d, en_p_d;
  logic csl, wr_rise, en_rise, en_fall;

  always_comb begin
    wr_p_d = wr_s;
    en_p_d = en_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p_q <= 1'b1;
      en_p_q <= 1'b1;
    end else begin
      wr_p_q <= wr_p_d;
      en_p_q <= en_p_d;
    end
  end

  always_comb begin
    csl     = ~cs_n_s;
    wr_rise = wr_s & ~wr_p_q;
    en_rise = en_s & ~en_p_q;
    en_fall = ~en_s & en_p_q;
    evt       = '0;
    evt.cs_on = csl;
    if (mode == XF_SERIAL) begin
      evt.sclk = csl & wr_rise;
    end else if (!proto_6800) begin
      evt.wr     = csl & wr_rise;
      evt.rd_end = csl & en_rise;
      evt.rd_act = csl & ~en_s;
    end else begin
      evt.wr     = csl & en_fall & ~wr_s;
      evt.rd_end = csl & en_fall & wr_s;
      evt.rd_act = csl & wr_s & en_s;
    end
  end
endmodule

// File: rtl/hostbus_assembler.sv
module hostbus_assembler
  import hostbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xfer_mode_e    mode,
  input  bus_evt_t      evt,
  input  logic [DW-1:0] din_s,
  input  logic          rs_s,
  input  logic [DW-1:0] rd_ir_data,
  input  logic [DW-1:0] rd_dr_data,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          wr_rs,
  output logic          rd_ack,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  localparam int NW = DW / 2;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic          phase_q, phase_d;
  logic [NW-1:0] hi_q, hi_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wv_q, wv_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          wrs_q, wrs_d;
  logic          ack_q, ack_d;
  logic          oe_q, oe_d;
  logic [DW-1:0] do_q, do_d;
  logic [DW-1:0] rbyte;

  always_comb begin
    rbyte   = rs_s ? rd_dr_data : rd_ir_data;
    phase_d = phase_q;
    hi_d    = hi_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    wv_d    = 1'b0;
    wd_d    = wd_q;
    wrs_d   = wrs_q;
    ack_d   = 1'b0;
    oe_d    = evt.rd_act;
    do_d    = '0;

    if (evt.rd_act) begin
      if (mode == XF_NIB4) begin
        do_d[DW-1 -: NW] = phase_q ? rbyte[NW-1:0] : rbyte[DW-1 -: NW];
      end else begin
        do_d = rbyte;
      end
    end

    if (evt.wr) begin
      if (mode == XF_NIB4) begin
        if (!phase_q) begin
          hi_d    = din_s[DW-1 -: NW];
          phase_d = 1'b1;
        end else begin
          wv_d    = 1'b1;
          wd_d    = {hi_q, din_s[DW-1 -: NW]};
          wrs_d   = rs_s;
          phase_d = 1'b0;
        end
      end else begin
        wv_d  = 1'b1;
        wd_d  = din_s;
        wrs_d = rs_s;
      end
    end

    if (evt.rd_end) begin
      if (mode == XF_NIB4) begin
        ack_d   = phase_q;
        phase_d = ~phase_q;
      end else begin
        ack_d = 1'b1;
      end
    end

    if (mode != XF_NIB4) phase_d = 1'b0;

    if (mode != XF_SERIAL || !evt.cs_on) begin
      cnt_d = '0;
    end else if (evt.sclk) begin
      sh_d = {sh_q[DW-2:0], din_s[0]};
      if (cnt_q == CNT_LAST) begin
        wv_d  = 1'b1;
        wd_d  = sh_d;
        wrs_d = rs_s;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      wv_q    <= 1'b0;
      wd_q    <= '0;
      wrs_q   <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      do_q    <= '0;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      wv_q    <= wv_d;
      wd_q    <= wd_d;
      wrs_q   <= wrs_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      do_q    <= do_d;
    end
  end

  assign wr_valid = wv_q;
  assign wr_data  = wd_q;
  assign wr_rs    = wrs_q;
  assign rd_ack   = ack_q;
  assign dout     = do_q;
  assign dout_oe  = oe_q;
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hostbus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_6800,
  input  logic          sel_par,
  input  logic          sel_wide,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_ir_data,
  input  logic [DW-1:0] rd_dr_data,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          wr_rs,
  output logic          rd_ack,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  localparam int SW = DW + 4;
  localparam logic [SW-1:0] PIN_IDLE = {{DW{1'b0}}, 4'b0111};

  logic          rst_i_n;
  logic [SW-1:0] pins_raw, pins_s;
  logic [DW-1:0] din_s;
  logic          rs_s, cs_n_s, wr_s, en_s;
  xfer_mode_e    mode;
  bus_evt_t      evt;

  assign pins_raw = {din, rs, cs_n, ctl_wr, ctl_en};
  assign {din_s, rs_s, cs_n_s, wr_s, en_s} = pins_s;
  assign mode = mode_of(sel_par, sel_wide);

  hostbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_i_n(rst_i_n)
  );

  hostbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(pins_raw), .q(pins_s)
  );

  hostbus_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_i_n), .proto_6800(sel_6800), .mode(mode),
    .cs_n_s(cs_n_s), .wr_s(wr_s), .en_s(en_s), .evt(evt)
  );

  hostbus_assembler #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_i_n), .mode(mode), .evt(evt),
    .din_s(din_s), .rs_s(rs_s),
    .rd_ir_data(rd_ir_data), .rd_dr_data(rd_dr_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_rs(wr_rs),
    .rd_ack(rd_ack), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_i_n,
  input logic          sel_par,
  input logic          wr_valid,
  input logic          rd_ack,
  input logic          dout_oe,
  input logic [DW-1:0] dout
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_i_n |-> (!wr_valid && !rd_ack && !dout_oe && dout == '0));

  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  p_single_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_single_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  p_serial_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_par && $past(!sel_par) && $past(!sel_par, 2)) |-> !dout_oe);
endmodule

bind hostbus_port hostbus_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_i_n(rst_i_n), .sel_par(sel_par),
  .wr_valid(wr_valid), .rd_ack(rd_ack), .dout_oe(dout_oe), .dout(dout)
);

// File: tb/hostbus_port_bench.sv
module hostbus_port_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_6800, sel_par, sel_wide, cs_n, rs, ctl_wr, ctl_en;
  logic [DW-1:0] din, rd_ir_data, rd_dr_data;
  logic wr_valid, wr_rs, rd_ack, dout_oe;
  logic [DW-1:0] wr_data, dout;

  always #2 clk = ~clk;

  hostbus_port u_hostbus_port (
    .clk(clk), .rst_n(rst_n), .sel_6800(sel_6800), .sel_par(sel_par),
    .sel_wide(sel_wide), .cs_n(cs_n), .rs(rs), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .din(din), .rd_ir_data(rd_ir_data), .rd_dr_data(rd_dr_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_rs(wr_rs), .rd_ack(rd_ack),
    .dout(dout), .dout_oe(dout_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit started = 0;
  bit done = 0;

  // reference model state; sample layout {din, rs, cs_n, ctl_wr, ctl_en}
  localparam logic [11:0] IDLE = 12'b0000_0000_0111;
  logic [11:0] h0, h1, h2, h3;
  int m_phase, m_cnt;
  logic [3:0] m_hi;
  logic [7:0] m_sh;
  logic e_wv, e_wrs, e_ack, e_oe;
  logic [7:0] e_wd, e_do;

  int n_wr = 0, n_ack = 0;
  logic [7:0] last_wd;
  logic last_rs;

  always @(posedge clk) begin
    logic [7:0] cd, rb;
    logic crs, ccs, ca, cb, pa, pb, csl, nib4, ser;
    logic ev_wr, ev_rd, ev_sc, act;
    started = 1;
    if (!rst_n) begin
      h0 = IDLE; h1 = IDLE; h2 = IDLE; h3 = IDLE;
      m_phase = 0; m_cnt = 0; m_hi = 0; m_sh = 0;
      e_wv = 0; e_wrs = 0; e_ack = 0; e_oe = 0; e_wd = 0; e_do = 0;
    end else begin
      h3 = h2; h2 = h1; h1 = h0; h0 = {din, rs, cs_n, ctl_wr, ctl_en};
      {cd, crs, ccs, ca, cb} = h2;
      pa = h3[1]; pb = h3[0];
      csl = !ccs; nib4 = sel_par && !sel_wide; ser = !sel_par;
      ev_wr = 0; ev_rd = 0; ev_sc = 0; act = 0;
      if (ser) ev_sc = csl && ca && !pa;
      else if (!sel_6800) begin
        ev_wr = csl && ca && !pa; ev_rd = csl && cb && !pb; act = csl && !cb;
      end else begin
        ev_wr = csl && !cb && pb && !ca; ev_rd = csl && !cb && pb && ca; act = csl && ca && cb;
      end
      rb = crs ? rd_dr_data : rd_ir_data;
      e_oe = act; e_do = 0; e_wv = 0; e_ack = 0;
      if (act) e_do = nib4 ? (m_phase != 0 ? {rb[3:0], 4'h0} : {rb[7:4], 4'h0}) : rb;
      if (ev_wr) begin
        if (nib4) begin
          if (m_phase == 0) begin m_hi = cd[7:4]; m_phase = 1; end
          else begin e_wv = 1; e_wd = {m_hi, cd[7:4]}; e_wrs = crs; m_phase = 0; end
        end else begin e_wv = 1; e_wd = cd; e_wrs = crs; end
      end
      if (ev_rd) begin
        if (nib4) begin e_ack = (m_phase == 1); m_phase = 1 - m_phase; end
        else e_ack = 1;
      end
      if (!nib4) m_phase = 0;
      if (!ser || !csl) m_cnt = 0;
      else if (ev_sc) begin
        m_sh = {m_sh[6:0], cd[0]};
        m_cnt++;
        if (m_cnt == 8) begin e_wv = 1; e_wd = m_sh; e_wrs = crs; m_cnt = 0; end
      end
    end
  end

  task automatic fail(input string req, input string what, input int act, input int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (wr_valid !== e_wv) fail(cur_req, "wr_valid", wr_valid, e_wv);
      else if (e_wv && (wr_data !== e_wd || wr_rs !== e_wrs))
        fail(cur_req, "wr_data/rs", {wr_rs, wr_data}, {e_wrs, e_wd});
      else if (rd_ack !== e_ack) fail(cur_req, "rd_ack", rd_ack, e_ack);
      else if (dout_oe !== e_oe) fail(cur_req, "dout_oe", dout_oe, e_oe);
      else if (dout !== e_do) fail(cur_req, "dout", dout, e_do);
      else if (!dout_oe && dout !== 8'h00) fail("R10", "dout idle", dout, 0);
      if (wr_valid === 1'b1) begin n_wr++; last_wd = wr_data; last_rs = wr_rs; end
      if (rd_ack === 1'b1) n_ack++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) fail(req, what, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    cs_n = 1; ctl_wr = 1; ctl_en = sel_6800 ? 1'b0 : 1'b1;
  endtask

  task automatic wr_a(input logic r, input logic [7:0] d);
    cs_n = 0; rs = r; din = d; cyc(3);
    ctl_wr = 0; cyc(3); ctl_wr = 1; cyc(3); cs_n = 1; cyc(3);
  endtask

  task automatic rd_a(input logic r);
    cs_n = 0; rs = r; cyc(3);
    ctl_en = 0; cyc(4); ctl_en = 1; cyc(3); cs_n = 1; cyc(3);
  endtask

  task automatic wr_b(input logic r, input logic [7:0] d);
    cs_n = 0; ctl_wr = 0; rs = r; din = d; cyc(3);
    ctl_en = 1; cyc(3); ctl_en = 0; cyc(3); ctl_wr = 1; cs_n = 1; cyc(3);
  endtask

  task automatic rd_b(input logic r);
    cs_n = 0; ctl_wr = 1; rs = r; cyc(3);
    ctl_en = 1; cyc(4); ctl_en = 0; cyc(3); cs_n = 1; cyc(3);
  endtask

  task automatic ser_byte(input logic r, input logic [7:0] d, input int nbits);
    cs_n = 0; rs = r; cyc(2);
    for (int i = 7; i > 7 - nbits; i--) begin
      din[0] = d[i]; cyc(2); ctl_wr = 0; cyc(2); ctl_wr = 1; cyc(2);
    end
    cs_n = 1; cyc(3);
  endtask

  task automatic finish_up();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail("WATCHDOG", "timeout", 0, 1);
    finish_up();
  end

  initial begin
    int w0, a0;
    rst_n = 0; sel_6800 = 0; sel_par = 1; sel_wide = 1;
    rs = 0; din = 0; rd_ir_data = 8'h3C; rd_dr_data = 8'hA5;
    idle_pins();
    cyc(4);
    check(wr_valid === 0 && rd_ack === 0 && dout_oe === 0 && dout === 0,
          "R1", "reset outputs", {wr_valid, rd_ack, dout_oe}, 0);
    rst_n = 1; cyc(6);

    cur_req = "R2"; w0 = n_wr;
    wr_a(0, 8'h5A);
    check(n_wr == w0 + 1 && last_wd == 8'h5A && last_rs == 0, "R2", "8080 write", last_wd, 8'h5A);
    cur_req = "R5";
    wr_a(1, 8'hC3);
    check(last_wd == 8'hC3 && last_rs == 1, "R5", "rs to data reg", last_rs, 1);

    cur_req = "R7"; a0 = n_ack;
    rd_a(0); rd_a(1);
    check(n_ack == a0 + 2, "R7", "8080 read acks", n_ack - a0, 2);

    cur_req = "R4"; w0 = n_wr; a0 = n_ack;
    din = 8'hFF; ctl_wr = 0; cyc(3); ctl_wr = 1; cyc(3);
    ctl_en = 0; cyc(4); ctl_en = 1; cyc(4);
    check(n_wr == w0 && n_ack == a0 && dout_oe === 0, "R4", "deselected strobes", n_wr - w0, 0);

    cur_req = "R3"; sel_6800 = 1; idle_pins(); cyc(4); w0 = n_wr;
    wr_b(1, 8'h96);
    check(n_wr == w0 + 1 && last_wd == 8'h96 && last_rs == 1, "R3", "6800 write", last_wd, 8'h96);
    wr_b(0, 8'h01);
    cur_req = "R7"; a0 = n_ack;
    rd_b(1); rd_b(0);
    check(n_ack == a0 + 2, "R7", "6800 read acks", n_ack - a0, 2);

    cur_req = "R6"; sel_wide = 0; cyc(4); w0 = n_wr;
    wr_b(0, 8'hE0);
    check(n_wr == w0, "R6", "no pulse after first nibble", n_wr - w0, 0);
    wr_b(1, 8'h70);
    check(n_wr == w0 + 1 && last_wd == 8'hE7 && last_rs == 1, "R6", "6800 nibble pair", last_wd, 8'hE7);
    sel_6800 = 0; idle_pins(); cyc(4);
    wr_a(0, 8'h20); wr_a(0, 8'hB0);
    check(last_wd == 8'h2B && last_rs == 0, "R6", "8080 nibble pair", last_wd, 8'h2B);

    cur_req = "R8"; a0 = n_ack;
    rd_a(1);
    check(n_ack == a0, "R8", "no ack after high nibble", n_ack - a0, 0);
    rd_a(1);
    check(n_ack == a0 + 1, "R8", "ack after low nibble", n_ack - a0, 1);
    rd_ir_data = 8'h4D; rd_a(0); rd_a(0);

    cur_req = "R1"; w0 = n_wr;
    wr_a(0, 8'h90);
    rst_n = 0; cyc(3); rst_n = 1; cyc(6);
    wr_a(0, 8'h10); wr_a(0, 8'h80);
    check(n_wr == w0 + 1 && last_wd == 8'h18, "R1", "phase cleared by reset", last_wd, 8'h18);

    cur_req = "R9"; sel_par = 0; sel_wide = 0; cyc(4); w0 = n_wr;
    ser_byte(1, 8'hD2, 8);
    check(n_wr == w0 + 1 && last_wd == 8'hD2 && last_rs == 1, "R9", "serial byte", last_wd, 8'hD2);
    sel_wide = 1; cyc(2);
    ser_byte(0, 8'hFF, 5);
    check(n_wr == w0 + 1, "R9", "partial byte dropped", n_wr - w0, 1);
    ser_byte(0, 8'h6B, 8);
    check(n_wr == w0 + 2 && last_wd == 8'h6B && last_rs == 0, "R9", "serial with wide strap", last_wd, 8'h6B);
    cs_n = 0; ctl_en = 0; cyc(5);
    check(dout_oe === 0, "R9", "serial never drives", dout_oe, 0);
    cs_n = 1; ctl_en = 1; cyc(4);

    finish_up();
  end
endmodule